// File: doc/BRIEF.md
# DC-Balanced Three-Lane Word Deserializer

This block rebuilds parallel words from three serial lanes whose bits arrive one per cycle of a bit-rate clock, nine bit times for each parallel word. A one-cycle `frame_start` pulse marks the first bit of a frame, on all lanes at once. Each lane frame opens with two polarity flags, A then B. Seven payload bits follow, most significant first.

The transmitter may have inverted a lane's payload to keep the line DC-balanced, and the flags say whether it did. The block shifts each lane into its own register and counts the frame out from the strobe. It then undoes the inversion lane by lane and loads the 21-bit result into an output register with a one-cycle `out_valid` pulse. A flag pair that is not complementary is a coding error. It sets a sticky `code_error` output, and that lane's payload is passed through unchanged.

Top module: `dcb_lane_deser`

## Requirements
- R1: A synchronous reset clears `out_word`, `out_valid` and `code_error`. All three read 0 on the cycle after a reset edge.
- R2: If `frame_start` is sampled high on clock edge k, then `out_valid` is high for exactly one cycle, from edge k+9 to edge k+10. It never stays high on two consecutive cycles.
- R3: On each lane the bits arrive in this order: flag A on the strobe cycle, then flag B, then payload bits 6 down to 0. Lane 2 feeds `out_word[20:14]`, lane 1 feeds `out_word[13:7]` and lane 0 feeds `out_word[6:0]`, each with its payload bit 6 in the highest position.
- R4: The flag pair {A,B} = 2'b10 means the lane payload was inverted, and the block outputs its bitwise complement. The pair 2'b01 means the payload is output as received.
- R5: A flag pair of 2'b00 or 2'b11 on any lane passes that lane's payload through unchanged. It also sets `code_error` on the same cycle that the word's `out_valid` is high.
- R6: Once set, `code_error` stays high until reset, including across later error-free words.
- R7: Frames sent back to back, with a strobe every nine cycles, each produce their own word with no cycle lost.
- R8: A `frame_start` that arrives before a frame is complete restarts alignment. The partial frame produces no word.
- R9: Lane bits sent while no frame is in progress produce no `out_valid`. `out_word` holds its value between `out_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, nine cycles per parallel word |
| rst | input | 1 | Synchronous active-high reset |
| lane_bit | input | 3 | One sampled serial bit per lane, bit index = lane number |
| frame_start | input | 1 | High on the cycle carrying flag A of a new frame |
| out_word | output | 21 | Recovered parallel word, held between valid pulses |
| out_valid | output | 1 | One-cycle pulse when a new word is loaded |
| code_error | output | 1 | Sticky flag: some lane carried equal polarity flags |

## Verification
The assertions assume that `frame_start` is a clean single-cycle marker aligned to flag A. They also assume the lane bits are already sampled at the ideal phase, so any nine consecutive bits after the strobe form a frame. The stimulus never leaves that envelope. Frames are built in the bench from a word, an inversion mask and an error mask, with strobes back to back, with idle gaps, or deliberately cut short to test realignment. Between frames the lane bits are random, and no strobe is sent. The sweep pairs all 128 values of a seven-bit payload with all eight per-lane inversion masks. Each word's expected value and expected delivery cycle are computed in the bench.

// File: rtl/dcb_deser_pkg.sv
package dcb_deser_pkg;

   // number of polarity flags ahead of the payload on every lane
   localparam int unsigned FLAG_W = 2;

   // {A,B} flag pair as it sits in the top two bits of a lane frame
   typedef enum logic [FLAG_W-1:0] {
      FLAGS_LOW   = 2'b00,
      FLAGS_PLAIN = 2'b01,
      FLAGS_INV   = 2'b10,
      FLAGS_HIGH  = 2'b11
   } flag_pair_e;

endpackage

// File: rtl/dcb_frame_align.sv
module dcb_frame_align #(
   parameter int unsigned FRAME_W = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic frame_start,
   output logic word_ready
);

   localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

   logic [CNT_W-1:0] bit_cnt;

   if (FRAME_W < 2) begin : g_bad_frame
      $error("dcb_frame_align: FRAME_W must be at least 2");
   end

   // counts bits captured in the current frame; zero means idle
   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt <= '0;
      end else if (frame_start) begin
         bit_cnt <= CNT_W'(1);
      end else if (bit_cnt != '0 && bit_cnt != LAST) begin
         bit_cnt <= bit_cnt + CNT_W'(1);
      end else begin
         bit_cnt <= '0;
      end
   end

   assign word_ready = (bit_cnt == LAST);

   p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
      bit_cnt <= LAST);

   p_realign_r8: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> (bit_cnt == CNT_W'(1)));

endmodule

// File: rtl/dcb_lane_shift.sv
module dcb_lane_shift #(
   parameter int unsigned FRAME_W = 9
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bit_in,
   output logic [FRAME_W-1:0] frame
);

   // oldest bit ends up at the top: flag A in FRAME_W-1 after a full frame
   always_ff @(posedge clk) begin
      if (rst) begin
         frame <= '0;
      end else begin
         frame <= {frame[FRAME_W-2:0], bit_in};
      end
   end

endmodule

// File: rtl/dcb_lane_restore.sv
module dcb_lane_restore
   import dcb_deser_pkg::*;
#(
   parameter int unsigned PAY_W = 7,
   localparam int unsigned FRAME_W = PAY_W + FLAG_W
) (
   input  logic [FRAME_W-1:0] frame,
   output logic [PAY_W-1:0]   payload,
   output logic               bad_flags
);

   flag_pair_e flags;

   assign flags = flag_pair_e'(frame[FRAME_W-1 -: FLAG_W]);

   always_comb begin
      payload   = frame[PAY_W-1:0];
      bad_flags = 1'b0;
      case (flags)
         FLAGS_INV:   payload = ~frame[PAY_W-1:0];
         FLAGS_PLAIN: payload = frame[PAY_W-1:0];
         default:     bad_flags = 1'b1;
      endcase
   end

endmodule

// File: rtl/dcb_lane_deser.sv
module dcb_lane_deser
   import dcb_deser_pkg::*;
#(
   parameter int unsigned LANES = 3,
   parameter int unsigned PAY_W = 7,
   localparam int unsigned FRAME_W = PAY_W + FLAG_W,
   localparam int unsigned OUT_W = LANES * PAY_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LANES-1:0] lane_bit,
   input  logic             frame_start,
   output logic [OUT_W-1:0] out_word,
   output logic             out_valid,
   output logic             code_error
);

   logic             word_ready;
   logic [OUT_W-1:0] restored;
   logic [LANES-1:0] lane_bad;

   if (LANES < 1) begin : g_bad_lanes
      $error("dcb_lane_deser: LANES must be at least 1");
   end
   if (PAY_W < 1) begin : g_bad_pay
      $error("dcb_lane_deser: PAY_W must be at least 1");
   end

   dcb_frame_align #(.FRAME_W(FRAME_W)) align_i (
      .clk         (clk),
      .rst         (rst),
      .frame_start (frame_start),
      .word_ready  (word_ready)
   );

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [FRAME_W-1:0] frame;

      dcb_lane_shift #(.FRAME_W(FRAME_W)) shift_i (
         .clk    (clk),
         .rst    (rst),
         .bit_in (lane_bit[ln]),
         .frame  (frame)
      );

      dcb_lane_restore #(.PAY_W(PAY_W)) restore_i (
         .frame     (frame),
         .payload   (restored[ln*PAY_W +: PAY_W]),
         .bad_flags (lane_bad[ln])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_word   <= '0;
         out_valid  <= 1'b0;
         code_error <= 1'b0;
      end else begin
         out_valid <= word_ready;
         if (word_ready) begin
            out_word <= restored;
            if (|lane_bad) begin
               code_error <= 1'b1;
            end
         end
      end
   end

   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_word));

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      code_error |=> code_error);

   p_err_with_word_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(code_error) |-> out_valid);

endmodule

// File: tb/dcb_lane_deser_tb_top.sv
module dcb_lane_deser_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  lane_bit = 3'b000;
   logic        frame_start = 1'b0;
   logic [20:0] out_word;
   logic        out_valid;
   logic        code_error;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit exp_sticky = 1'b0;
   bit done = 1'b0;

   logic [20:0] q_word[$];
   int          q_due[$];
   bit          q_err[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dcb_lane_deser dut_i (
      .clk         (clk),
      .rst         (rst),
      .lane_bit    (lane_bit),
      .frame_start (frame_start),
      .out_word    (out_word),
      .out_valid   (out_valid),
      .code_error  (code_error)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // R2 R3 R4 R5 R7 R8: every delivered word is matched against the queue
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (q_word.size() == 0) begin
            check(1'b0, "R8 R9 unexpected out_valid", out_word, 0);
         end else begin
            logic [20:0] w;
            int          due;
            bit          e;
            w   = q_word.pop_front();
            due = q_due.pop_front();
            e   = q_err.pop_front();
            check(cyc == due, "R2 out_valid cycle", cyc, due);
            check(out_word == w, "R3 R4 recovered word", out_word, w);
            check(code_error == e, "R5 R6 code_error", code_error, e);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame_start = 1'b0;
         lane_bit    = 3'($urandom);
      end
   endtask

   // flags {1,0} invert, {0,1} plain, equal flags for an error lane
   task automatic send_frame(input logic [20:0] w, input logic [2:0] inv,
                             input logic [2:0] bad);
      logic [8:0] fr[3];
      for (int l = 0; l < 3; l++) begin
         logic [6:0] p;
         logic       a;
         p = w[l*7 +: 7];
         a = 1'($urandom);
         if (bad[l])      fr[l] = {a, a, p};
         else if (inv[l]) fr[l] = {2'b10, ~p};
         else             fr[l] = {2'b01, p};
      end
      for (int k = 0; k < 9; k++) begin
         @(negedge clk);
         frame_start = (k == 0);
         for (int l = 0; l < 3; l++) lane_bit[l] = fr[l][8-k];
         if (k == 0) begin
            exp_sticky = exp_sticky | (|bad);
            q_word.push_back(w);
            q_due.push_back(cyc + 10);
            q_err.push_back(exp_sticky);
         end
      end
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst = 1'b1;
      frame_start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(out_word == 0, "R1 reset out_word", out_word, 0);
      check(out_valid == 0, "R1 reset out_valid", out_valid, 0);
      check(code_error == 0, "R1 reset code_error", code_error, 0);
      exp_sticky = 1'b0;
      rst = 1'b0;
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired: run hung");
         summary();
         $finish;
      end
   end

   initial begin
      do_reset();

      // R4 R7: all 128 payloads against all 8 inversion masks, back to back
      for (int v = 0; v < 128; v++) begin
         for (int m = 0; m < 8; m++) begin
            logic [6:0] b;
            b = 7'(v);
            send_frame({b, b ^ 7'h2A ^ {4'b0, 3'(m)}, ~b}, 3'(m), 3'b000);
         end
      end
      idle(12);
      check(q_word.size() == 0, "R7 all back-to-back words delivered",
            q_word.size(), 0);

      // R3 R4: random words with random gaps
      for (int i = 0; i < 300; i++) begin
         send_frame(21'($urandom), 3'($urandom), 3'b000);
         idle($urandom_range(0, 3));
      end
      idle(12);
      check(q_word.size() == 0, "R3 random words delivered", q_word.size(), 0);

      // R8: a new strobe cuts a partial frame short
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         frame_start = 1'b1;
         lane_bit = 3'($urandom);
         idle(1 + i);
         send_frame(21'($urandom), 3'($urandom), 3'b000);
      end
      idle(12);
      check(q_word.size() == 0, "R8 only restarted frames delivered",
            q_word.size(), 0);

      // R9: bits with no strobe are ignored and the word holds
      begin
         logic [20:0] held;
         held = out_word;
         idle(60);
         check(out_word == held, "R9 out_word held while idle", out_word, held);
         check(out_valid == 0, "R9 no out_valid while idle", out_valid, 0);
      end

      // R5 R6: equal flags on each lane in turn
      for (int l = 0; l < 3; l++) begin
         check(code_error == 0, "R5 code_error clear before bad frame",
               code_error, 0);
         send_frame(21'($urandom), 3'($urandom), 3'(1 << l));
         idle(20);
         check(code_error == 1, "R6 code_error stays set", code_error, 1);
         send_frame(21'($urandom), 3'b000, 3'b000);
         send_frame(21'($urandom), 3'b111, 3'b000);
         idle(12);
         check(code_error == 1, "R6 code_error survives clean words",
               code_error, 1);
         do_reset();
      end

      // R5: all lanes bad at once
      send_frame(21'($urandom), 3'b000, 3'b111);
      idle(12);
      check(code_error == 1, "R5 all-lane error flagged", code_error, 1);
      check(q_word.size() == 0, "R5 error word delivered", q_word.size(), 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule